// File: doc/BRIEF.md
# BCD Clock-Calendar Core with Hundredths

This block keeps wall-clock time and calendar date as eight packed-BCD bytes. It resolves time down to one hundredth of a second, and it counts upward through seconds, minutes, hours, day of week, day of month, month and two-digit year. The carry from each unit feeds the next one. A single-cycle enable at 100 Hz, made by a divider outside this block, advances the count. The divider and any access logic that moves bytes in or out serially are left to the surrounding design.

The full 64-bit state can be written in a single cycle through a load port. It is always visible on a 64-bit output. Byte k of either bus sits at bits 8k+7..8k:

- 0: hundredths
- 1: seconds
- 2: minutes
- 3: hours
- 4: weekday plus control
- 5: date
- 6: month
- 7: year

The hours byte selects between a 12-hour and a 24-hour count. The weekday byte also carries a run/halt bit and a stored-only mask bit. The core shortens months that have fewer than 31 days and puts a 29th day in February of leap years.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the output reads year 00, month 01, date 01, weekday 01, hours 00 (24-hour), minutes 00, seconds 00, hundredths 00, with the halt bit equal to the RST_STOPPED parameter (default 0).
- R2: Each cycle with `tick_i` high, no load and the halt bit clear, hundredths (byte 0, tenths digit in bits 7:4, hundredths digit in bits 3:0) advances by one BCD count. Without a tick the output holds.
- R3: Hundredths wrap from 99 to 00 and carry into seconds. Seconds and minutes each wrap from 59 to 00 and carry into the next unit in the same tick.
- R4: With hours bit 7 at 0 (24-hour), hours run 00 to 23 with bits 5:4 as the tens digit. 23 wraps to 00 and advances the date.
- R5: With hours bit 7 at 1 (12-hour), bits 4:0 hold 01 to 12 and bit 5 is the half-day flag (1 = PM). 11 goes to 12 and toggles the flag. 12 goes to 01 with the flag kept. Only 11 PM to 12 AM advances the date.
- R6: Weekday-byte bit 5 set to 1 halts all counting. Bit 4 is only stored and has no effect on counting. Neither bit changes except by a load.
- R7: The last date is 30 for months 04, 06, 09 and 11, 28 for month 02 in a non-leap year, and 31 otherwise. After the last date comes date 01 of the next month.
- R8: Any year value divisible by four, 00 included, is a leap year and gives February a 29th.
- R9: The weekday (bits 2:0 of byte 4) runs 01 to 07 and goes back to 01 on the tick that advances the date. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R10: Bits that carry no field always read 0, whatever was loaded into them. These are: bit 7 of bytes 1 and 2, bit 6 of byte 3, bits 7, 6 and 3 of byte 4, bits 7:6 of byte 5, and bits 7:5 of byte 6.
- R11: A load wins over a tick in the same cycle. The output then shows exactly the loaded value, with the R10 bits cleared, and counting resumes from it on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 100 Hz advance enable |
| load_i | input | 1 | Whole-state write strobe |
| load_data_i | input | 64 | Eight BCD bytes to write, byte k at bits 8k+7..8k |
| time_o | output | 64 | Current eight BCD bytes, same layout |

## Verification
Some properties are checked by the checker on every cycle:
- the unused bits read zero;
- the output holds when there is neither a tick nor a load;
- the output holds while halted;
- the control bits change only through a load;
- a load shows up unchanged one cycle later;
- the hundredths digit steps by one when it is not about to wrap.

Other behaviour can only be shown by the bench's directed scenarios. These cover the whole carry cascade, the 12-hour half-day transitions and the month-length and leap-year boundaries. They also cover the weekday, month and year wraps and the collision of a tick with a load.

// File: rtl/cal_pkg.sv
package cal_pkg;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned NUM_BYTE = 8;
   localparam int unsigned STATE_W  = BYTE_W * NUM_BYTE;

   typedef logic [BYTE_W-1:0] bcd8_t;

   // byte slots (behaviour depends on carry order)
   localparam int unsigned IX_HSEC  = 0;
   localparam int unsigned IX_SEC   = 1;
   localparam int unsigned IX_MIN   = 2;
   localparam int unsigned IX_HOUR  = 3;
   localparam int unsigned IX_WDAY  = 4;
   localparam int unsigned IX_DATE  = 5;
   localparam int unsigned IX_MONTH = 6;
   localparam int unsigned IX_YEAR  = 7;

   localparam int unsigned HR_FMT_BIT  = 7;
   localparam int unsigned HR_HALF_BIT = 5;
   localparam int unsigned WD_HALT_BIT = 5;
   localparam int unsigned WD_MASK_BIT = 4;

   // bits that hold a field; everything else reads zero
   localparam logic [STATE_W-1:0] LIVE_BITS =
      {8'hFF, 8'h1F, 8'h3F, 8'h37, 8'hBF, 8'h7F, 8'h7F, 8'hFF};

   function automatic bcd8_t bcd_next(input bcd8_t v);
      bcd8_t r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   function automatic logic is_leap(input bcd8_t yr);
      logic r;
      if (yr[4] == 1'b0) r = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
      else               r = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
      return r;
   endfunction

   function automatic bcd8_t last_date(input bcd8_t mon, input bcd8_t yr);
      bcd8_t r;
      case (mon)
         8'h02:                      r = is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
         default:                    r = 8'h31;
      endcase
      return r;
   endfunction

   function automatic logic bcd_legal(input bcd8_t v);
      return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
   endfunction

endpackage

// File: rtl/cal_bcd_stage.sv
module cal_bcd_stage
   import cal_pkg::*;
#(
   parameter bcd8_t FIRST = 8'h00,
   parameter bcd8_t LAST  = 8'h59
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load_i,
   input  bcd8_t load_val_i,
   input  logic  step_i,
   output bcd8_t val_o,
   output logic  wrap_o
);

   bcd8_t cnt_q;
   logic  at_end;

   assign at_end = (cnt_q >= LAST);
   assign wrap_o = step_i & at_end;
   assign val_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= FIRST;
      else if (load_i) cnt_q <= load_val_i;
      else if (step_i) cnt_q <= at_end ? FIRST : bcd_next(cnt_q);
   end

endmodule

// File: rtl/cal_hour_stage.sv
module cal_hour_stage
   import cal_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load_i,
   input  bcd8_t load_val_i,
   input  logic  step_i,
   output bcd8_t val_o,
   output logic  day_wrap_o
);

   bcd8_t hr_q;
   bcd8_t hr_nx;
   logic  wrap_c;
   logic  fmt12;
   logic  half;
   bcd8_t h12;
   bcd8_t h24;

   assign fmt12 = hr_q[HR_FMT_BIT];
   assign half  = hr_q[HR_HALF_BIT];
   assign h12   = {3'b000, hr_q[4:0]};
   assign h24   = {2'b00, hr_q[5:0]};

   always_comb begin
      hr_nx  = hr_q;
      wrap_c = 1'b0;
      if (fmt12) begin
         if (h12 == 8'h12) begin
            hr_nx = {1'b1, 1'b0, half, 5'h01};
         end else if (h12 == 8'h11) begin
            hr_nx  = {1'b1, 1'b0, ~half, 5'h12};
            wrap_c = half;
         end else begin
            hr_nx = {1'b1, 1'b0, half, bcd_next(h12)[4:0]};
         end
      end else begin
         if (h24 >= 8'h23) begin
            hr_nx  = 8'h00;
            wrap_c = 1'b1;
         end else begin
            hr_nx = {2'b00, bcd_next(h24)[5:0]};
         end
      end
   end

   assign day_wrap_o = step_i & wrap_c;
   assign val_o      = hr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hr_q <= 8'h00;
      else if (load_i) hr_q <= load_val_i;
      else if (step_i) hr_q <= hr_nx;
   end

endmodule

// File: rtl/cal_date_stage.sv
module cal_date_stage
   import cal_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load_i,
   input  bcd8_t load_val_i,
   input  logic  step_i,
   input  bcd8_t month_i,
   input  bcd8_t year_i,
   output bcd8_t val_o,
   output logic  month_wrap_o
);

   bcd8_t dt_q;
   bcd8_t lim;
   logic  at_end;

   assign lim          = last_date(month_i, year_i);
   assign at_end       = (dt_q >= lim);
   assign month_wrap_o = step_i & at_end;
   assign val_o        = dt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dt_q <= 8'h01;
      else if (load_i) dt_q <= load_val_i;
      else if (step_i) dt_q <= at_end ? 8'h01 : bcd_next(dt_q);
   end

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
   import cal_pkg::*;
#(
   parameter bit    RST_STOPPED = 1'b0,
   parameter bcd8_t SUBSEC_LAST = 8'h99
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic               load_i,
   input  logic [STATE_W-1:0] load_data_i,
   output logic [STATE_W-1:0] time_o
);

   localparam int unsigned N_FAST = 3;

   generate
      if (!bcd_legal(SUBSEC_LAST)) begin : g_bad_subsec
         $error("SUBSEC_LAST must be a legal BCD byte");
      end
   endgenerate

   logic [STATE_W-1:0] ld;
   logic               halt_q;
   logic               mask_q;
   logic               run;
   logic [N_FAST:0]    carry;
   bcd8_t              fast_val [N_FAST];
   bcd8_t              hr_val, wd_val, dt_val, mo_val, yr_val;
   logic               day_wrap, mo_step, yr_step, yr_wrap_unused;

   assign ld  = load_data_i & LIVE_BITS;
   assign run = tick_i & ~halt_q & ~load_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= RST_STOPPED;
         mask_q <= 1'b0;
      end else if (load_i) begin
         halt_q <= ld[IX_WDAY*BYTE_W + WD_HALT_BIT];
         mask_q <= ld[IX_WDAY*BYTE_W + WD_MASK_BIT];
      end
   end

   assign carry[0] = run;

   for (genvar i = 0; i < N_FAST; i++) begin : g_fast
      localparam bcd8_t LIM = (i == 0) ? SUBSEC_LAST : 8'h59;
      cal_bcd_stage #(.FIRST(8'h00), .LAST(LIM)) u_stage (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_i    (load_i),
         .load_val_i(ld[i*BYTE_W +: BYTE_W]),
         .step_i    (carry[i]),
         .val_o     (fast_val[i]),
         .wrap_o    (carry[i+1])
      );
   end

   cal_hour_stage u_hour (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load_i),
      .load_val_i(ld[IX_HOUR*BYTE_W +: BYTE_W]),
      .step_i    (carry[N_FAST]),
      .val_o     (hr_val),
      .day_wrap_o(day_wrap)
   );

   cal_bcd_stage #(.FIRST(8'h01), .LAST(8'h07)) u_wday (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load_i),
      .load_val_i({5'b00000, ld[IX_WDAY*BYTE_W +: 3]}),
      .step_i    (day_wrap),
      .val_o     (wd_val),
      .wrap_o    ()
   );

   cal_date_stage u_date (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load_i),
      .load_val_i  (ld[IX_DATE*BYTE_W +: BYTE_W]),
      .step_i      (day_wrap),
      .month_i     (mo_val),
      .year_i      (yr_val),
      .val_o       (dt_val),
      .month_wrap_o(mo_step)
   );

   cal_bcd_stage #(.FIRST(8'h01), .LAST(8'h12)) u_month (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load_i),
      .load_val_i(ld[IX_MONTH*BYTE_W +: BYTE_W]),
      .step_i    (mo_step),
      .val_o     (mo_val),
      .wrap_o    (yr_step)
   );

   cal_bcd_stage #(.FIRST(8'h00), .LAST(8'h99)) u_year (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load_i),
      .load_val_i(ld[IX_YEAR*BYTE_W +: BYTE_W]),
      .step_i    (yr_step),
      .val_o     (yr_val),
      .wrap_o    (yr_wrap_unused)
   );

   assign time_o = {yr_val, mo_val, dt_val,
                    {2'b00, halt_q, mask_q, 1'b0, wd_val[2:0]},
                    hr_val, fast_val[2], fast_val[1], fast_val[0]};

endmodule

// File: rtl/cal_core_checker.sv
module cal_core_checker
   import cal_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               tick_i,
   input logic               load_i,
   input logic [STATE_W-1:0] load_data_i,
   input logic [STATE_W-1:0] time_o
);

   localparam int unsigned HALT_POS = IX_WDAY*BYTE_W + WD_HALT_BIT;
   localparam int unsigned MASK_POS = IX_WDAY*BYTE_W + WD_MASK_BIT;

   a_r10_dead_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (time_o & ~LIVE_BITS) == '0);

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load_i) |=> $stable(time_o));

   a_r2_hundredth_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !load_i && !time_o[HALT_POS] && time_o[3:0] < 4'd9)
      |=> time_o[3:0] == $past(time_o[3:0]) + 4'd1);

   a_r6_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && time_o[HALT_POS]) |=> $stable(time_o));

   a_r6_ctrl_only_by_load: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(time_o[HALT_POS]) && $stable(time_o[MASK_POS])));

   a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> time_o == ($past(load_data_i) & LIVE_BITS));

endmodule

bind bcd_calendar_core cal_core_checker u_chk (.*);

// File: tb/bcd_calendar_core_bench.sv
module bcd_calendar_core_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        load_i = 1'b0;
   logic [63:0] load_data_i = '0;
   logic [63:0] time_o;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   bcd_calendar_core u_bcd_calendar_core (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i),
      .load_data_i(load_data_i), .time_o(time_o)
   );

   function automatic logic [63:0] mk(input logic [7:0] yr, mo, dt, wd, hr, mi, se, hs);
      return {yr, mo, dt, wd, hr, mi, se, hs};
   endfunction

   task automatic check(input string req, input logic [63:0] exp);
      checks++;
      if (time_o !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, time_o, exp);
      end
   endtask

   task automatic do_load(input logic [63:0] v);
      @(negedge clk);
      load_i = 1'b1;
      load_data_i = v;
      @(negedge clk);
      load_i = 1'b0;
   endtask

   task automatic do_ticks(input int n);
      @(negedge clk);
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic one_step(input string req, input logic [63:0] from, input logic [63:0] to);
      do_load(from);
      do_ticks(1);
      check(req, to);
   endtask

   task automatic t_reset;
      check("R1 reset", mk(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
   endtask

   task automatic t_basic;
      do_load('0 | mk(8'h21, 8'h03, 8'h15, 8'h03, 8'h10, 8'h00, 8'h00, 8'h00));
      do_ticks(1);
      check("R2 single tick", mk(8'h21, 8'h03, 8'h15, 8'h03, 8'h10, 8'h00, 8'h00, 8'h01));
      do_ticks(9);
      check("R2 tenth digit", mk(8'h21, 8'h03, 8'h15, 8'h03, 8'h10, 8'h00, 8'h00, 8'h10));
      repeat (6) @(negedge clk);
      check("R2 idle hold", mk(8'h21, 8'h03, 8'h15, 8'h03, 8'h10, 8'h00, 8'h00, 8'h10));
   endtask

   task automatic t_chain;
      one_step("R3 seconds carry",
               mk(8'h21, 8'h03, 8'h15, 8'h03, 8'h10, 8'h05, 8'h59, 8'h99),
               mk(8'h21, 8'h03, 8'h15, 8'h03, 8'h10, 8'h06, 8'h00, 8'h00));
      one_step("R4 24h midnight",
               mk(8'h21, 8'h03, 8'h15, 8'h03, 8'h23, 8'h59, 8'h59, 8'h99),
               mk(8'h21, 8'h03, 8'h16, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00));
      one_step("R4 24h 19 to 20",
               mk(8'h21, 8'h03, 8'h15, 8'h03, 8'h19, 8'h59, 8'h59, 8'h99),
               mk(8'h21, 8'h03, 8'h15, 8'h03, 8'h20, 8'h00, 8'h00, 8'h00));
   endtask

   task automatic t_12h;
      one_step("R5 11AM to 12PM",
               mk(8'h21, 8'h03, 8'h15, 8'h03, 8'h91, 8'h59, 8'h59, 8'h99),
               mk(8'h21, 8'h03, 8'h15, 8'h03, 8'hB2, 8'h00, 8'h00, 8'h00));
      one_step("R5 11PM to 12AM",
               mk(8'h21, 8'h03, 8'h15, 8'h03, 8'hB1, 8'h59, 8'h59, 8'h99),
               mk(8'h21, 8'h03, 8'h16, 8'h04, 8'h92, 8'h00, 8'h00, 8'h00));
      one_step("R5 12PM to 01PM",
               mk(8'h21, 8'h03, 8'h15, 8'h03, 8'hB2, 8'h59, 8'h59, 8'h99),
               mk(8'h21, 8'h03, 8'h15, 8'h03, 8'hA1, 8'h00, 8'h00, 8'h00));
      one_step("R5 12AM to 01AM",
               mk(8'h21, 8'h03, 8'h15, 8'h03, 8'h92, 8'h59, 8'h59, 8'h99),
               mk(8'h21, 8'h03, 8'h15, 8'h03, 8'h81, 8'h00, 8'h00, 8'h00));
      one_step("R5 09AM to 10AM",
               mk(8'h21, 8'h03, 8'h15, 8'h03, 8'h89, 8'h59, 8'h59, 8'h99),
               mk(8'h21, 8'h03, 8'h15, 8'h03, 8'h90, 8'h00, 8'h00, 8'h00));
   endtask

   task automatic t_halt;
      do_load(mk(8'h21, 8'h03, 8'h15, 8'h23, 8'h10, 8'h00, 8'h00, 8'h00));
      do_ticks(5);
      check("R6 halted", mk(8'h21, 8'h03, 8'h15, 8'h23, 8'h10, 8'h00, 8'h00, 8'h00));
      do_load(mk(8'h21, 8'h03, 8'h15, 8'h13, 8'h10, 8'h00, 8'h00, 8'h00));
      do_ticks(3);
      check("R6 mask bit inert", mk(8'h21, 8'h03, 8'h15, 8'h13, 8'h10, 8'h00, 8'h00, 8'h03));
   endtask

   task automatic t_months;
      one_step("R7 April end",
               mk(8'h21, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
               mk(8'h21, 8'h05, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
      one_step("R7 April 29",
               mk(8'h21, 8'h04, 8'h29, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
               mk(8'h21, 8'h04, 8'h30, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
      one_step("R7 January end",
               mk(8'h21, 8'h01, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
               mk(8'h21, 8'h02, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
      one_step("R7 Feb non-leap",
               mk(8'h21, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
               mk(8'h21, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
      one_step("R7 Feb year 10",
               mk(8'h10, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
               mk(8'h10, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
      one_step("R8 Feb 28 year 24",
               mk(8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
               mk(8'h24, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
      one_step("R8 Feb 29 year 24",
               mk(8'h24, 8'h02, 8'h29, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
               mk(8'h24, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
      one_step("R8 Feb year 00",
               mk(8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
               mk(8'h00, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
      one_step("R8 Feb year 12",
               mk(8'h12, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
               mk(8'h12, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
   endtask

   task automatic t_wraps;
      one_step("R9 year rollover",
               mk(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59, 8'h99),
               mk(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
      one_step("R9 December to January",
               mk(8'h21, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59, 8'h99),
               mk(8'h22, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00));
   endtask

   task automatic t_dead_bits;
      do_load({64{1'b1}});
      check("R10 dead bits", 64'hFF1F_3F37_BF7F_7FFF);
   endtask

   task automatic t_collision;
      logic [63:0] v;
      v = mk(8'h21, 8'h06, 8'h10, 8'h02, 8'h08, 8'h30, 8'h45, 8'h50);
      @(negedge clk);
      load_i = 1'b1;
      tick_i = 1'b1;
      load_data_i = v;
      @(negedge clk);
      load_i = 1'b0;
      tick_i = 1'b0;
      check("R11 load beats tick", v);
      do_ticks(1);
      check("R11 resumes from load", mk(8'h21, 8'h06, 8'h10, 8'h02, 8'h08, 8'h30, 8'h45, 8'h51));
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_basic();
            t_chain();
            t_12h();
            t_halt();
            t_months();
            t_wraps();
            t_dead_bits();
            t_collision();
         end
         begin
            repeat (100000) @(posedge clk);
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule